// File: doc/BRIEF.md
# Line-Interface Serial Register Master

This block runs the control port of a line-interface device. The requester places a 4-bit register number, a read/write flag and the write data on the inputs, then pulses `start`. The block then drives one frame of sixteen serial clock pulses with chip select held high. The frame carries three fields in order: an operation bit, an address field padded to seven bits, and a data field of eight bits. All multi-bit fields are sent least significant bit first.

A write sends five data bits followed by zero padding. A read uses the last eight pulses to take bits from the device's serial output, and the resulting byte appears on `rdata`. The serial clock runs at the system clock divided by `2*HALF_DIV`. `busy` covers the whole transaction, and a single-cycle `done` marks its end.

Top module: `sreg_master`

## Requirements
- R1: After reset, `cs`, `sclk`, `sdo`, `busy`, `done` and `rdata` are all zero.
- R2: Serial bit 0 of every frame is the operation bit, 1 for a read and 0 for a write.
- R3: Serial bits 1 to 4 carry `addr[0]` to `addr[3]`, and serial bits 5 to 7 are zero.
- R4: On a write, serial bits 8 to 12 carry `wdata[0]` to `wdata[4]` and bits 13 to 15 are zero. `wdata[7:5]` has no effect on the frame.
- R5: On a read, `sdo` stays low during serial bits 8 to 15. `sdi` is sampled while `sclk` is high on pulses 9 to 16, and the sample taken on pulse 9+k becomes `rdata[k]`.
- R6: Each bit is driven onto `sdo` while `sclk` is low. Each half period of `sclk` lasts `HALF_DIV` clock cycles, and a frame has exactly 16 rising edges of `sclk`.
- R7: `cs` stays high for the whole frame. After the last pulse, `sclk` stays low with `cs` still high for `HALF_DIV` cycles. After that, `cs`, `sclk` and `sdo` are all low.
- R8: `busy` is high for `33*HALF_DIV` cycles, starting the cycle after `start` is accepted. `done` is then high for exactly one cycle, and `busy` is low during that cycle.
- R9: A `start` that arrives while `busy` is high is ignored: the running frame and its duration are unchanged.
- R10: `rdata` keeps its value until the next read completes. A write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transaction (accepted when idle) |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Device register number |
| wdata | input | 8 | Write data; only bits 4:0 are sent |
| sdi | input | 1 | Serial data from the device |
| cs | output | 1 | Chip select, active high |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last byte read |

## Verification
Most wrong internal states show up at the ports within one frame:
- A phase counter that slips shows up as a wrong pulse count, or as high and low widths other than `HALF_DIV`.
- A misindexed frame bit or capture index shows up as a wrong serial pattern, or as a wrong `rdata` right after `done`.

Two faults take longer to appear. A state machine that leaves the tail early or late shows up only as a `busy` length other than `33*HALF_DIV`, or as `cs` dropping while `sclk` is high. A corrupt `rdata` register under writes shows up only on the next write's `done`.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } sreg_state_e;
endpackage

// File: rtl/sreg_tick.sv
module sreg_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sreg_capture.sv
module sreg_capture #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  logic          sdi,
  output logic [W-1:0]  data
);
  always_ff @(posedge clk) begin
    if (rst || clr) data <= '0;
    else if (en)    data[idx] <= sdi;
  end
endmodule

// File: rtl/sreg_master.sv
module sreg_master #(
  parameter int HALF_DIV  = 2,
  parameter int ADDR_W    = 4,
  parameter int WDATA_W   = 5,
  parameter int AFIELD_W  = 7,
  parameter int DFIELD_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                is_read,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DFIELD_W-1:0] wdata,
  input  logic                sdi,
  output logic                cs,
  output logic                sclk,
  output logic                sdo,
  output logic                busy,
  output logic                done,
  output logic [DFIELD_W-1:0] rdata
);
  import sreg_pkg::*;

  localparam int FRAME_BITS = 1 + AFIELD_W + DFIELD_W;
  localparam int PW         = $clog2(2 * FRAME_BITS);
  localparam int BW         = PW - 1;
  localparam int DIW        = (DFIELD_W > 1) ? $clog2(DFIELD_W) : 1;
  localparam logic [PW-1:0] LAST_PHASE = PW'(2 * FRAME_BITS - 1);
  localparam logic [BW-1:0] DSTART     = BW'(1 + AFIELD_W);

  // Serial position i of the frame is bit i of the result.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                rw,
    input logic [ADDR_W-1:0]   a,
    input logic [DFIELD_W-1:0] d
  );
    logic [FRAME_BITS-1:0] f;
    f    = '0;
    f[0] = rw;
    for (int i = 0; i < ADDR_W; i++) f[1 + i] = a[i];
    if (!rw)
      for (int i = 0; i < WDATA_W; i++) f[1 + AFIELD_W + i] = d[i];
    return f;
  endfunction

  sreg_state_e           state;
  logic [PW-1:0]         phase;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  rd_q;
  logic                  tick;
  logic [DFIELD_W-1:0]   rx;

  // named internal events
  wire           accept    = (state == ST_IDLE) && start;
  wire           in_run    = (state == ST_RUN);
  wire [BW-1:0]  cur_bit   = phase[PW-1:1];
  wire           in_data   = (cur_bit >= DSTART);
  wire           frame_end = in_run && tick && (phase == LAST_PHASE);
  wire           tail_end  = (state == ST_TAIL) && tick;
  wire           sample_en = in_run && tick && phase[0] && rd_q && in_data;
  wire [BW-1:0]  cap_off   = cur_bit - DSTART;
  wire [DIW-1:0] cap_idx   = cap_off[DIW-1:0];

  sreg_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (state != ST_IDLE),
    .tick(tick)
  );

  sreg_capture #(.W(DFIELD_W), .IW(DIW)) u_cap (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .en  (sample_en),
    .idx (cap_idx),
    .sdi (sdi),
    .data(rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          phase   <= '0;
          frame_q <= build_frame(is_read, addr, wdata);
          rd_q    <= is_read;
        end
        ST_RUN: if (tick) begin
          if (phase == LAST_PHASE) state <= ST_TAIL;
          else                     phase <= phase + 1'b1;
        end
        ST_TAIL: if (tick) begin
          state <= ST_IDLE;
          done  <= 1'b1;
          if (rd_q) rdata <= rx;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs   = (state != ST_IDLE);
  assign busy = cs;
  assign sclk = in_run && phase[0];
  assign sdo  = in_run && frame_q[cur_bit];

  // ---------------- assertions ----------------
  logic          sclk_d;
  logic [PW:0]   pulse_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      sclk_d <= sclk;
      if (accept)             pulse_cnt <= '0;
      else if (sclk && !sclk_d) pulse_cnt <= pulse_cnt + 1'b1;
    end
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (!sclk && !sdo));

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pulse_cnt == (PW+1)'(FRAME_BITS)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  op_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs) |-> (sdo == rd_q));

  // R5
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_run && rd_q && in_data) |-> !sdo);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(rd_q) && $stable(frame_q)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(tail_end && rd_q) |=> $stable(rdata));
endmodule

// File: tb/sim_sreg_master.sv
module sim_sreg_master;
  localparam int HD = 2;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, is_read = 1'b0, sdi = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic cs, sclk, sdo, busy, done;
  logic [7:0] rdata;

  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  sreg_master #(.HALF_DIV(HD)) u0 (
    .clk(clk), .rst(rst), .start(start), .is_read(is_read), .addr(addr),
    .wdata(wdata), .sdi(sdi), .cs(cs), .sclk(sclk), .sdo(sdo),
    .busy(busy), .done(done), .rdata(rdata)
  );

  // vector: {rw, addr[3:0], wdata[7:0], read byte[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'h9, 8'h00, 8'hA5},
    {1'b0, 4'h3, 8'h1F, 8'h00},
    {1'b0, 4'hF, 8'hE2, 8'h00},
    {1'b1, 4'h0, 8'h00, 8'hFF},
    {1'b1, 4'hF, 8'h00, 8'h01},
    {1'b0, 4'h6, 8'h15, 8'h00},
    {1'b1, 4'hA, 8'h00, 8'h80}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic rw, input logic [3:0] a,
                                            input logic [7:0] d);
    logic [15:0] f = 16'h0;
    f[0] = rw;
    f[4:1] = a;
    if (!rw) f[12:8] = d[4:0];
    return f;
  endfunction

  // device model / monitor
  logic [7:0]  cur_rb = '0;
  logic [15:0] cap = '0, last_frame = '0;
  int cnt = 0, last_cnt = 0, lowrun = 0, highrun = 0, last_low = 0, width_err = 0;
  logic prev_sclk = 1'b0, prev_cs = 1'b0;

  always @(negedge clk) begin
    if (cs) begin
      if (!prev_cs) width_err = 0;
      if (sclk && !prev_sclk) begin
        if (cnt < 16) cap[cnt] = sdo;
        cnt++;
        if (lowrun != HD) width_err++;
        lowrun = 0;
        highrun = 1;
      end else if (!sclk && prev_sclk) begin
        if (highrun != HD) width_err++;
        highrun = 0;
        lowrun = 1;
        sdi = (cnt >= 8 && cnt < 16) ? cur_rb[cnt-8] : 1'b0;
      end else if (sclk) highrun++;
      else lowrun++;
    end else if (prev_cs) begin
      last_frame = cap;
      last_cnt = cnt;
      last_low = lowrun;
      cnt = 0; cap = '0; lowrun = 0; highrun = 0; sdi = 1'b0;
    end
    prev_sclk = sclk;
    prev_cs = cs;
  end

  task automatic txn(input logic rw, input logic [3:0] a, input logic [7:0] d,
                     input logic [7:0] rb, input bit inject, output int bcnt);
    int guard = 0;
    cur_rb = rb;
    @(negedge clk);
    is_read = rw; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0;
    while (!done && guard < 5000) begin
      if (busy) bcnt++;
      if (inject && bcnt == 20) begin
        start = 1'b1; is_read = ~rw; addr = ~a; wdata = ~d;
      end else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(done, "R8 done seen", done, 1);
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    check(!cs && !sclk && !sdo, "R7 idle after frame", {cs, sclk, sdo}, 0);
  endtask

  logic [7:0] exp_rd = '0;

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({cs, sclk, sdo, busy, done} == 5'b0, "R1 reset outputs", {cs, sclk, sdo, busy, done}, 0);
    check(rdata == 8'h00, "R1 reset rdata", rdata, 0);

    for (int v = 0; v < NV; v++) begin
      logic rw;
      logic [3:0] a;
      logic [7:0] d, rb;
      {rw, a, d, rb} = VEC[v];
      txn(rw, a, d, rb, 1'b0, bc);
      // R2 R3 R4 R5: frame content
      check(last_frame == exp_frame(rw, a, d), "R2/R3/R4 frame bits", last_frame, exp_frame(rw, a, d));
      check(last_cnt == 16, "R6 pulse count", last_cnt, 16);
      check(width_err == 0, "R6 half-period width", width_err, 0);
      check(last_low == HD, "R7 tail low", last_low, HD);
      check(bc == 33 * HD, "R8 busy length", bc, 33 * HD);
      if (rw) exp_rd = rb;
      check(rdata == exp_rd, rw ? "R5 read byte" : "R10 rdata held", rdata, exp_rd);
    end

    // R4: upper write bits ignored
    txn(1'b0, 4'h5, 8'hE0, 8'h00, 1'b0, bc);
    check(last_frame == 16'h000A, "R4 wdata[7:5] ignored", last_frame, 16'h000A);

    // R9: start while busy ignored
    txn(1'b1, 4'hC, 8'h00, 8'h3C, 1'b1, bc);
    check(last_frame == exp_frame(1'b1, 4'hC, 8'h00), "R9 frame unchanged", last_frame,
          exp_frame(1'b1, 4'hC, 8'h00));
    check(bc == 33 * HD, "R9 busy length unchanged", bc, 33 * HD);
    check(rdata == 8'h3C, "R9 read result", rdata, 8'h3C);
    repeat (3) @(negedge clk);
    check(!busy && !cs, "R9 no second frame", {busy, cs}, 0);

    // R10: write after read keeps rdata
    txn(1'b0, 4'h1, 8'h0B, 8'hFF, 1'b0, bc);
    check(rdata == 8'h3C, "R10 rdata held after write", rdata, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule